// File: doc/BRIEF.md
# Coprocessor Multi-Word Store Sequencer

This block is the processor-side cycle sequencer for an instruction that moves data from a coprocessor out to memory. After a one-cycle start pulse it enters an issue cycle. In that cycle it presents the opcode-fetch address pc+8 and asserts the active-low coprocessor instruction strobe. In the same cycle it reads the two handshake lines that the coprocessor drives back: the "absent" line and the "busy" line.

When both lines are low the coprocessor is ready. When only busy is high the sequencer holds in busy-wait cycles with memory idle, and it raises a memory request in the cycle in which busy falls. It then runs write cycles. The first write goes to the word-aligned base address supplied by the ALU, and each further word goes four bytes higher, while the coprocessor places the data on the bus. The coprocessor sets the length of the burst: it raises both handshake lines on the final word. The sequencer then pulses a one-cycle completion flag and issues a non-sequential instruction fetch at pc+12. If the absent line is high in the issue cycle, the block skips the transfer and pulses an undefined-instruction flag.

Top module: `cop_store_seq`

## Requirements
- R1: After reset the block is idle. Its outputs are: memory idle high, instruction strobe high (inactive), opcode fetch flag high (inactive), write flag low, burst flag low, completion flag low, undefined flag low and address 0.
- R2: The cycle after an accepted start is the issue cycle. It drives address pc+8 with write low, opcode fetch flag low and instruction strobe low. Memory idle is 0 when both handshake lines are low and 1 otherwise.
- R3: A busy-wait cycle follows an issue cycle or busy-wait cycle that sees busy high with absent low. It drives address pc+8, opcode fetch flag high, instruction strobe low and write low. Memory idle equals the busy line, so it drops to 0 in the cycle in which busy falls. Transfers begin on the next cycle.
- R4: A transfer cycle drives write high, memory idle 0, opcode fetch flag high and instruction strobe high. The first transfer address is the base input with bits [1:0] cleared. Each further word is at the previous address plus 4, modulo 2^AW.
- R5: The burst flag is 1 on every transfer cycle except the last. The last transfer cycle is the one in which both handshake lines are high, and its burst flag is 0. This holds for a single-word transfer too.
- R6: The access size output is 2 (word) in every cycle.
- R7: After the last transfer, the completion flag is high for exactly one cycle, with address pc+12 and memory idle 1. The next cycle is a fetch: address pc+12, memory idle 0, burst 0, opcode fetch flag 0, instruction strobe 1. The block is then idle again.
- R8: If the absent line is high in the issue cycle, the next cycle pulses the undefined flag with idle outputs and no write cycle, and the block then returns to idle.
- R9: A start pulse that arrives while the block is not idle is ignored. The operation in progress runs unchanged and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted in idle |
| pc_i | input | AW | Program counter of the instruction, captured at start |
| base_i | input | AW | ALU-computed transfer base address, captured at start |
| cp_absent_i | input | 1 | Coprocessor handshake: absent / last-word line |
| cp_busy_i | input | 1 | Coprocessor handshake: busy / last-word line |
| addr_o | output | AW | Memory address |
| mem_idle_o | output | 1 | 1 = no memory request this cycle |
| burst_o | output | 1 | 1 = next access is sequential to this one |
| wr_o | output | 1 | 1 = write to memory |
| ifetch_n_o | output | 1 | 0 = this cycle is an opcode fetch |
| cop_instr_n_o | output | 1 | 0 = coprocessor instruction strobe active |
| size_o | output | 2 | Access size, 2 = word |
| done_o | output | 1 | One-cycle completion pulse |
| undef_o | output | 1 | One-cycle undefined-instruction pulse |

## Verification
The bench builds the block with the default AW of 32, so pc values and base addresses near the top of the address space can be tested. One burst starts at 0xFFFF_FFF8, which makes the per-word increment wrap through zero. A coprocessor model with a programmable busy count and word count covers these cases: zero busy cycles, several busy cycles, single-word bursts, multi-word bursts, an unaligned base address, an absent coprocessor, and a start pulse held high through a burst.

// File: rtl/cop_seq_pkg.sv
package cop_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_BUSY,
    ST_XFER,
    ST_DONE,
    ST_FETCH,
    ST_UNDEF
  } seq_state_e;

  localparam logic [1:0] SIZE_WORD   = 2'd2;
  localparam int unsigned STEP_BYTES = 4;
  localparam int unsigned ISSUE_OFF  = 8;
  localparam int unsigned RESUME_OFF = 12;

endpackage

// File: rtl/cop_seq_fsm.sv
module cop_seq_fsm
  import cop_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       cp_absent_i,
  input  logic       cp_busy_i,
  output seq_state_e state_o,
  output logic       ev_accept_o,
  output logic       ev_last_o
);

  seq_state_e state_q, state_d;

  // Named events shared with the address unit and the output decoder
  logic ev_absent, ev_stall;

  assign ev_accept_o = (state_q == ST_IDLE) && start_i;
  assign ev_absent   = (state_q == ST_ISSUE) && cp_absent_i;
  assign ev_stall    = ((state_q == ST_ISSUE) && !cp_absent_i && cp_busy_i) ||
                       ((state_q == ST_BUSY) && cp_busy_i);
  assign ev_last_o   = (state_q == ST_XFER) && cp_absent_i && cp_busy_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (ev_accept_o) state_d = ST_ISSUE;
      ST_ISSUE: begin
        if (ev_absent)     state_d = ST_UNDEF;
        else if (ev_stall) state_d = ST_BUSY;
        else               state_d = ST_XFER;
      end
      ST_BUSY:  if (!ev_stall) state_d = ST_XFER;
      ST_XFER:  if (ev_last_o) state_d = ST_DONE;
      ST_DONE:  state_d = ST_FETCH;
      ST_FETCH: state_d = ST_IDLE;
      ST_UNDEF: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/cop_seq_addr.sv
module cop_seq_addr
  import cop_seq_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] issue_addr_o,
  output logic [AW-1:0] resume_addr_o,
  output logic [AW-1:0] xfer_addr_o
);

  localparam logic [AW-1:0] STEP   = AW'(STEP_BYTES);
  localparam logic [AW-1:0] OFF_IS = AW'(ISSUE_OFF);
  localparam logic [AW-1:0] OFF_RS = AW'(RESUME_OFF);

  function automatic logic [AW-1:0] word_align(input logic [AW-1:0] a);
    return {a[AW-1:2], 2'b00};
  endfunction

  function automatic logic [AW-1:0] next_word(input logic [AW-1:0] a);
    return a + STEP;
  endfunction

  function automatic logic [AW-1:0] pc_plus(input logic [AW-1:0] pc,
                                            input logic [AW-1:0] off);
    return pc + off;
  endfunction

  logic [AW-1:0] pc_q, xa_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      xa_q <= '0;
    end else if (load_i) begin
      pc_q <= pc_i;
      xa_q <= word_align(base_i);
    end else if (step_i) begin
      xa_q <= next_word(xa_q);
    end
  end

  assign issue_addr_o  = pc_plus(pc_q, OFF_IS);
  assign resume_addr_o = pc_plus(pc_q, OFF_RS);
  assign xfer_addr_o   = xa_q;

endmodule

// File: rtl/cop_seq_outdec.sv
module cop_seq_outdec
  import cop_seq_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  seq_state_e    state_i,
  input  logic          cp_absent_i,
  input  logic          cp_busy_i,
  input  logic          ev_last_i,
  input  logic [AW-1:0] issue_addr_i,
  input  logic [AW-1:0] resume_addr_i,
  input  logic [AW-1:0] xfer_addr_i,
  output logic [AW-1:0] addr_o,
  output logic          mem_idle_o,
  output logic          burst_o,
  output logic          wr_o,
  output logic          ifetch_n_o,
  output logic          cop_instr_n_o,
  output logic [1:0]    size_o,
  output logic          done_o,
  output logic          undef_o
);

  always_comb begin
    addr_o        = '0;
    mem_idle_o    = 1'b1;
    burst_o       = 1'b0;
    wr_o          = 1'b0;
    ifetch_n_o    = 1'b1;
    cop_instr_n_o = 1'b1;
    done_o        = 1'b0;
    undef_o       = 1'b0;
    unique case (state_i)
      ST_ISSUE: begin
        addr_o        = issue_addr_i;
        ifetch_n_o    = 1'b0;
        cop_instr_n_o = 1'b0;
        mem_idle_o    = cp_absent_i | cp_busy_i;
      end
      ST_BUSY: begin
        addr_o        = issue_addr_i;
        cop_instr_n_o = 1'b0;
        mem_idle_o    = cp_busy_i;
      end
      ST_XFER: begin
        addr_o     = xfer_addr_i;
        wr_o       = 1'b1;
        mem_idle_o = 1'b0;
        burst_o    = !ev_last_i;
      end
      ST_DONE: begin
        addr_o = resume_addr_i;
        done_o = 1'b1;
      end
      ST_FETCH: begin
        addr_o     = resume_addr_i;
        mem_idle_o = 1'b0;
        ifetch_n_o = 1'b0;
      end
      ST_UNDEF: undef_o = 1'b1;
      default: ;
    endcase
  end

  assign size_o = SIZE_WORD;

endmodule

// File: rtl/cop_store_seq.sv
module cop_store_seq
  import cop_seq_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] base_i,
  input  logic          cp_absent_i,
  input  logic          cp_busy_i,
  output logic [AW-1:0] addr_o,
  output logic          mem_idle_o,
  output logic          burst_o,
  output logic          wr_o,
  output logic          ifetch_n_o,
  output logic          cop_instr_n_o,
  output logic [1:0]    size_o,
  output logic          done_o,
  output logic          undef_o
);

  seq_state_e    state;
  logic          ev_accept, ev_last, ev_step;
  logic [AW-1:0] issue_addr, resume_addr, xfer_addr;

  cop_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cp_absent_i (cp_absent_i),
    .cp_busy_i   (cp_busy_i),
    .state_o     (state),
    .ev_accept_o (ev_accept),
    .ev_last_o   (ev_last)
  );

  // Advance the word pointer on every transfer cycle that is not the last
  assign ev_step = (state == ST_XFER) && !ev_last;

  cop_seq_addr #(.AW(AW)) u_addr (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (ev_accept),
    .step_i        (ev_step),
    .pc_i          (pc_i),
    .base_i        (base_i),
    .issue_addr_o  (issue_addr),
    .resume_addr_o (resume_addr),
    .xfer_addr_o   (xfer_addr)
  );

  cop_seq_outdec #(.AW(AW)) u_dec (
    .state_i       (state),
    .cp_absent_i   (cp_absent_i),
    .cp_busy_i     (cp_busy_i),
    .ev_last_i     (ev_last),
    .issue_addr_i  (issue_addr),
    .resume_addr_i (resume_addr),
    .xfer_addr_i   (xfer_addr),
    .addr_o        (addr_o),
    .mem_idle_o    (mem_idle_o),
    .burst_o       (burst_o),
    .wr_o          (wr_o),
    .ifetch_n_o    (ifetch_n_o),
    .cop_instr_n_o (cop_instr_n_o),
    .size_o        (size_o),
    .done_o        (done_o),
    .undef_o       (undef_o)
  );

endmodule

// File: rtl/cop_store_seq_chk.sv
module cop_store_seq_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr_o,
  input logic          mem_idle_o,
  input logic          burst_o,
  input logic          wr_o,
  input logic          ifetch_n_o,
  input logic          cop_instr_n_o,
  input logic [1:0]    size_o,
  input logic          done_o,
  input logic          undef_o
);

  // R6
  size_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_o == 2'd2);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && $past(wr_o)) |-> (addr_o == $past(addr_o) + AW'(4)));

  // R4
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> (addr_o[1:0] == 2'b00));

  // R3
  req_before_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && !$past(wr_o)) |-> (!$past(mem_idle_o) && !$past(cop_instr_n_o)));

  // R5
  last_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(wr_o) && !$past(burst_o)));

  // R7
  resume_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!ifetch_n_o && !mem_idle_o && !burst_o && !done_o));

  // R8
  undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> (!wr_o && !done_o && mem_idle_o && !$past(wr_o)));

endmodule

bind cop_store_seq cop_store_seq_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .addr_o        (addr_o),
  .mem_idle_o    (mem_idle_o),
  .burst_o       (burst_o),
  .wr_o          (wr_o),
  .ifetch_n_o    (ifetch_n_o),
  .cop_instr_n_o (cop_instr_n_o),
  .size_o        (size_o),
  .done_o        (done_o),
  .undef_o       (undef_o)
);

// File: tb/cop_store_seq_tb.sv
`timescale 1ns/1ps
module cop_store_seq_tb;

  localparam int unsigned AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] pc_i = '0;
  logic [AW-1:0] base_i = '0;
  logic          cp_absent_i = 1'b0;
  logic          cp_busy_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic          mem_idle_o, burst_o, wr_o, ifetch_n_o, cop_instr_n_o;
  logic [1:0]    size_o;
  logic          done_o, undef_o;

  always #10 clk = ~clk;

  cop_store_seq #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pc_i(pc_i), .base_i(base_i),
    .cp_absent_i(cp_absent_i), .cp_busy_i(cp_busy_i), .addr_o(addr_o),
    .mem_idle_o(mem_idle_o), .burst_o(burst_o), .wr_o(wr_o),
    .ifetch_n_o(ifetch_n_o), .cop_instr_n_o(cop_instr_n_o), .size_o(size_o),
    .done_o(done_o), .undef_o(undef_o)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic [7:0]    flags; // idle,burst,wr,ifn,cin,done,undef,size_ok
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic push(input logic [AW-1:0] a, input logic idle, burst, wr,
                      ifn, cin, dn, ud, input string tag);
    exp_t e;
    e.addr  = a;
    e.flags = {idle, burst, wr, ifn, cin, dn, ud, 1'b1};
    e.tag   = tag;
    q.push_back(e);
  endtask

  task automatic drive(input logic st, input logic a, input logic b);
    @(negedge clk);
    start_i     = st;
    cp_absent_i = a;
    cp_busy_i   = b;
  endtask

  function automatic logic [7:0] actual_flags();
    return {mem_idle_o, burst_o, wr_o, ifetch_n_o, cop_instr_n_o, done_o,
            undef_o, (size_o == 2'd2)};
  endfunction

  // Monitor: pops one expected item per cycle, mid-way to the next edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rst_n && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (addr_o !== e.addr || actual_flags() !== e.flags) begin
          failures++;
          $display("FAIL %s: addr=%h flags=%b expected addr=%h flags=%b (R6 in flag bit0)",
                   e.tag, addr_o, actual_flags(), e.addr, e.flags);
        end
      end
    end
  end

  // Coprocessor model: busy_n cycles of busy, then words transfers
  task automatic run_op(input logic [AW-1:0] pc, input logic [AW-1:0] base,
                        input int busy_n, input int words, input bit absent,
                        input bit start_in_burst);
    logic [AW-1:0] wa;
    pc_i   = pc;
    base_i = base;
    drive(1'b1, 1'b0, 1'b0);
    push('0, 1, 0, 0, 1, 1, 0, 0, "R1");
    drive(1'b0, absent, (busy_n > 0) && !absent);
    // R2 issue cycle
    push(pc + 8, absent || (busy_n > 0), 0, 0, 0, 0, 0, 0, "R2");
    if (absent) begin
      drive(1'b0, 1'b0, 1'b0);
      push('0, 1, 0, 0, 1, 1, 0, 1, "R8");
      drive(1'b0, 1'b0, 1'b0);
      push('0, 1, 0, 0, 1, 1, 0, 0, "R8");
      return;
    end
    if (busy_n > 0) begin
      for (int i = 1; i < busy_n; i++) begin
        drive(1'b0, 1'b0, 1'b1);
        push(pc + 8, 1, 0, 0, 1, 0, 0, 0, "R3");
      end
      drive(1'b0, 1'b0, 1'b0);
      push(pc + 8, 0, 0, 0, 1, 0, 0, 0, "R3");
    end
    wa = {base[AW-1:2], 2'b00};
    for (int j = 0; j < words; j++) begin
      bit last;
      last = (j == words - 1);
      drive(start_in_burst, last, last);
      push(wa, 0, !last, 1, 1, 1, 0, 0, last ? "R5" : "R4");
      wa = wa + 4;
    end
    drive(1'b0, 1'b0, 1'b0);
    push(pc + 12, 1, 0, 0, 1, 1, 1, 0, "R7");
    drive(1'b0, 1'b0, 1'b0);
    push(pc + 12, 0, 0, 0, 0, 1, 0, 0, "R7");
    drive(1'b0, 1'b0, 1'b0);
    push('0, 1, 0, 0, 1, 1, 0, 0, start_in_burst ? "R9" : "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #5;
    // R1 reset state
    checks++;
    if (addr_o !== '0 || actual_flags() !== 8'b1001_1001) begin
      failures++;
      $display("FAIL R1: addr=%h flags=%b expected addr=0 flags=10011001",
               addr_o, actual_flags());
    end
    @(negedge clk);
    rst_n = 1'b1;
    run_op(32'h0000_1000, 32'h0000_2000, 0, 1, 0, 0);
    run_op(32'h0000_1100, 32'h0000_3000, 0, 4, 0, 0);
    run_op(32'h0000_1200, 32'h0000_4000, 3, 1, 0, 0);
    run_op(32'h0000_1300, 32'h0000_5003, 2, 2, 0, 0);
    run_op(32'h0000_1400, 32'h0000_6000, 1, 5, 0, 1);
    run_op(32'h0000_1500, 32'h0000_7000, 0, 3, 1, 0);
    run_op(32'hFFFF_FF00, 32'hFFFF_FFF8, 2, 4, 0, 0);
    repeat (3) @(negedge clk);
    #6;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R7: %0d expected items left unchecked, expected 0", q.size());
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule